// File: doc/BRIEF.md
# Half-Integer Clock Divider with 50% Duty Output

This block takes a fast clock and divides it by one of eight ratios chosen with a 3-bit code. The set includes the half-integer ratio 1.5 and the odd-based ratios 3, 6 and 12, as well as the plain powers of two. The divided clock drives a configurable number of output pairs. Each pair has a true line and a complementary line.

A select input chooses the divider's source clock. One setting picks the synthesizer's oscillator clock and the other picks the reference clock, which bypasses the loop. An active-high master reset holds the divider in a known state and forces every true output low at once.

Odd and half ratios are built from two stages that are combined: a counter on the rising edge and a stage on the falling edge. This places output edges on half-period boundaries of the source. A new code is adopted only when the current output cycle wraps, so a change never cuts a pulse short.

Top module: `halfstep_divider`

## Requirements
- R1: The output period is the ratio times the source period. The ratio is chosen by `div_code`, bit 0 being the LSB: 000 gives 1, 001 gives 1.5, 010 gives 2, 011 gives 3, 100 gives 4, 101 gives 6, 110 gives 8 and 111 gives 12.
- R2: For every integer ratio the output is high for exactly half its period. Code 000 reproduces the source clock.
- R3: Ratio 1.5 comes from a rising-edge stage and a falling-edge stage whose outputs are combined. Its period is three source half-periods, with two half-periods high and one low. This is the closest to 50% that edge resolution allows.
- R4: While `mreset` is high, every `out_p` bit is 0 and every `out_n` bit is 1. This takes effect without waiting for a clock edge, and the dividers are cleared at the next source rising edge.
- R5: After `mreset` falls, the first rising edge of `out_p` comes at the first rising edge of the source clock.
- R6: All output pairs carry the same waveform, and each `out_n` bit is the complement of its `out_p` bit.
- R7: With `use_ref` = 1 the divider runs from `ref_clk`; with 0 it runs from `vco_clk`. The select is changed only while `mreset` is high.
- R8: `div_code` is sampled only at the end of an output cycle. The cycle in progress completes with the old ratio.
- R9: Across a ratio change, no high pulse is shorter than the smaller of the old and new high times, and no low pulse is shorter than the smaller of the old and new low times. After the change the new period holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| vco_clk | input | 1 | Oscillator clock from the synthesizer loop |
| ref_clk | input | 1 | Reference clock, used when bypassing the loop |
| use_ref | input | 1 | Source select: 1 = reference, 0 = oscillator |
| mreset | input | 1 | Active-high master reset |
| div_code | input | 3 | Ratio code (see R1) |
| out_p | output | NUM_PAIRS | True outputs, one per pair |
| out_n | output | NUM_PAIRS | Complementary outputs, one per pair |

## Verification
Every code is swept on both source clocks, and the bench measures output period and high time in source half-periods. This catches a wrong entry in the ratio decode, a missing falling-edge stage (ratio 3 would come out at 33% duty), and a 1.5 pattern that repeats every third cycle instead of every half-cycle.

Mid-cycle code changes are made through a chain of ratio transitions, and every pulse width is checked against the smaller of the old and new widths. A divider that took the code at once would cut a 12-period pulse short or emit a runt. The bench also times the first edge after reset release, so a counter that restarted at zero and not at the wrap point would show a late first edge. Finally, reset is raised mid-pulse to catch a reset that waits for a clock edge.

// File: rtl/hdiv_pkg.sv
// Shared definitions for the half-integer divider.
// Assumes a 3-bit ratio code; a code's ratio entry is computed, not tabulated.
package hdiv_pkg;
    localparam int CODE_W     = 3;
    localparam int MAX_PERIOD = 12;
    localparam int CNT_W      = $clog2(MAX_PERIOD + 1);

    // Per-code counter settings: cycle length, rising-stage high window,
    // falling-stage window (start and length), all in source cycles.
    typedef struct packed {
        logic [CNT_W-1:0] period;
        logic [CNT_W-1:0] pa_len;
        logic [CNT_W-1:0] pn_start;
        logic [CNT_W-1:0] pn_len;
    } ratio_t;

    function automatic ratio_t ratio_lookup(input logic [CODE_W-1:0] code);
        ratio_t r;
        int     p;
        int     sh;
        sh = int'(code[2:1]);
        if (code == CODE_W'(0))      p = 1;
        else if (code == CODE_W'(1)) p = 3;
        else                         p = (code[0] ? 3 : 2) << (sh - 1);
        r.period = CNT_W'(p);
        r.pa_len = (code == CODE_W'(0)) ? CNT_W'(1) : CNT_W'(p / 2);
        if (code == CODE_W'(1)) begin
            r.pn_start = CNT_W'(1);
            r.pn_len   = CNT_W'(1);
        end else if ((p % 2 == 1) && (p > 1)) begin
            r.pn_start = CNT_W'(0);
            r.pn_len   = CNT_W'(p / 2);
        end else begin
            r.pn_start = CNT_W'(0);
            r.pn_len   = CNT_W'(0);
        end
        return r;
    endfunction
endpackage

// File: rtl/hdiv_clk_sel.sv
// Source clock select. Assumes the select only moves while the divider
// is held in reset, so a glitch at the switch cannot upset counting.
module hdiv_clk_sel (
    input  logic vco_clk,
    input  logic ref_clk,
    input  logic use_ref,
    output logic src_clk
);
    // Route either the oscillator or the reference to the divider.
    assign src_clk = use_ref ? ref_clk : vco_clk;
endmodule

// File: rtl/hdiv_seq.sv
// Rising-edge part of the divider: cycle counter, code capture at cycle
// wrap, and the two window flags feeding the output combiner.
// Assumes synchronous active-low reset; reset parks the counter on its
// last count so the first clock after release starts a fresh cycle.
module hdiv_seq
    import hdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] code,
    output logic              pa_q,
    output logic              pn_q,
    output logic              thru_q
);
    logic [CNT_W-1:0]  cnt_q, cnt_n;
    logic [CODE_W-1:0] cfg_q, cfg_n;
    ratio_t            cur, nxt, rst_info;
    logic              wrap;
    logic              pa_n, pn_n;

    // Next-state decode: wrap detection, code adoption, window flags.
    always_comb begin
        cur      = ratio_lookup(cfg_q);
        rst_info = ratio_lookup(code);
        wrap     = (cnt_q >= cur.period - 1'b1);
        cfg_n    = wrap ? code : cfg_q;
        cnt_n    = wrap ? '0 : cnt_q + 1'b1;
        nxt      = ratio_lookup(cfg_n);
        pa_n     = (cnt_n < nxt.pa_len);
        pn_n     = (cnt_n >= nxt.pn_start) &&
                   ({1'b0, cnt_n} < ({1'b0, nxt.pn_start} + {1'b0, nxt.pn_len}));
    end

    // State update on the source rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= code;
            cnt_q  <= rst_info.period - 1'b1;
            pa_q   <= 1'b0;
            pn_q   <= 1'b0;
            thru_q <= 1'b0;
        end else begin
            cfg_q  <= cfg_n;
            cnt_q  <= cnt_n;
            pa_q   <= pa_n;
            pn_q   <= pn_n;
            thru_q <= (cfg_n == '0);
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < cur.period); // R1
    AST_CODE_HELD_MIDCYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wrap |=> $stable(cfg_q)); // R8
    AST_CYCLE_STARTS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> pa_q); // R9
    AST_FIRST_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(rst_n, 2) && $past(rst_n)) |-> pa_q); // R5
endmodule

// File: rtl/hdiv_neg.sv
// Falling-edge stage: delays the rising-stage window flag by half a source
// period so odd and half ratios get edges on half-period boundaries.
// Assumes the same synchronous active-low reset, applied at the falling edge.
module hdiv_neg (
    input  logic clk,
    input  logic rst_n,
    input  logic pn_q,
    output logic na_q
);
    // Capture the window flag on the source falling edge.
    always_ff @(negedge clk) begin
        if (!rst_n) na_q <= 1'b0;
        else        na_q <= pn_q;
    end

    AST_HALF_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (na_q == pn_q)); // R3
endmodule

// File: rtl/halfstep_divider.sv
// Top of the half-integer divider. Selects the source clock, runs the
// rising and falling stages, and combines them into NUM_PAIRS identical
// complementary output pairs. Master reset is active high at the port and
// gates the outputs combinationally; inside it acts as a synchronous
// active-low reset.
module halfstep_divider
    import hdiv_pkg::*;
#(
    parameter int NUM_PAIRS = 2
) (
    input  logic                 vco_clk,
    input  logic                 ref_clk,
    input  logic                 use_ref,
    input  logic                 mreset,
    input  logic [CODE_W-1:0]    div_code,
    output logic [NUM_PAIRS-1:0] out_p,
    output logic [NUM_PAIRS-1:0] out_n
);
    logic src_clk;
    logic rst_n;
    logic pa_q, pn_q, thru_q, na_q;
    logic core;

    // Internal reset polarity.
    assign rst_n = ~mreset;

    hdiv_clk_sel u_sel (
        .vco_clk (vco_clk),
        .ref_clk (ref_clk),
        .use_ref (use_ref),
        .src_clk (src_clk)
    );

    hdiv_seq u_seq (
        .clk    (src_clk),
        .rst_n  (rst_n),
        .code   (div_code),
        .pa_q   (pa_q),
        .pn_q   (pn_q),
        .thru_q (thru_q)
    );

    hdiv_neg u_neg (
        .clk   (src_clk),
        .rst_n (rst_n),
        .pn_q  (pn_q),
        .na_q  (na_q)
    );

    // Combine both edge stages; ratio 1 passes the source clock through.
    assign core = ((pa_q & ~(thru_q & ~src_clk)) | na_q) & ~mreset;

    // Fan the divided clock out to every pair.
    for (genvar i = 0; i < NUM_PAIRS; i++) begin : g_pair
        assign out_p[i] = core;
        assign out_n[i] = ~core;
    end
endmodule

// File: tb/tb_halfstep_divider.sv
`timescale 1ns/1ps
module tb_halfstep_divider;
    localparam int CLK_PERIOD = 20;
    localparam int REF_PERIOD = 28;
    localparam int NUM_PAIRS  = 2;
    localparam int WD_CYCLES  = 100000;

    logic                 vco_clk = 1'b0;
    logic                 ref_clk = 1'b0;
    logic                 use_ref = 1'b0;
    logic                 mreset  = 1'b1;
    logic [2:0]           div_code = 3'd0;
    logic [NUM_PAIRS-1:0] out_p;
    logic [NUM_PAIRS-1:0] out_n;

    int checks = 0;
    int errors = 0;

    halfstep_divider #(.NUM_PAIRS(NUM_PAIRS)) dut (
        .vco_clk  (vco_clk),
        .ref_clk  (ref_clk),
        .use_ref  (use_ref),
        .mreset   (mreset),
        .div_code (div_code),
        .out_p    (out_p),
        .out_n    (out_n)
    );

    always #(CLK_PERIOD/2) vco_clk = ~vco_clk;
    always #(REF_PERIOD/2) ref_clk = ~ref_clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Output period in source half-periods, from the code mapping (R1).
    function automatic int halves_of(input logic [2:0] c);
        return (c[0] ? 3 : 2) << c[2:1];
    endfunction

    // High time in half-periods: half the period, or 2 of 3 for ratio 1.5.
    function automatic int high_of(input logic [2:0] c);
        return (c == 3'd1) ? 2 : halves_of(c) / 2;
    endfunction

    function automatic int half_ns(input logic s);
        return s ? REF_PERIOD / 2 : CLK_PERIOD / 2;
    endfunction

    task automatic wait_src_neg();
        if (use_ref) @(negedge ref_clk);
        else         @(negedge vco_clk);
    endtask

    // Reset, select, release; then check first edge, pairs, period, high time.
    task automatic run_code(input logic [2:0] c, input logic s);
        time t_rel, t0, t1, t2, t3, t4;
        int  h;
        string rp, rh;
        h  = half_ns(s);
        rp = s ? "R7" : ((c == 3'd1) ? "R3" : "R1");
        rh = (c == 3'd1) ? "R3" : "R2";
        mreset   = 1'b1;
        use_ref  = s;
        div_code = c;
        repeat (3) wait_src_neg();
        #1;
        chk(out_p == '0, "R4", out_p, 0);
        chk(out_n == '1, "R4", out_n, 3);
        mreset = 1'b0;
        t_rel  = $time;
        @(posedge out_p[0]);
        t0 = $time;
        chk((t0 - t_rel) == time'(h - 1), "R5", t0 - t_rel, h - 1);
        #1;
        chk(out_p == '1 && out_n == '0, "R6", {out_p, out_n}, 4'b1100);
        @(negedge out_p[0]); t1 = $time;
        @(posedge out_p[0]); t2 = $time;
        @(negedge out_p[0]); t3 = $time;
        @(posedge out_p[0]); t4 = $time;
        chk((t2 - t0) == time'(halves_of(c) * h), rp, t2 - t0, halves_of(c) * h);
        chk((t4 - t2) == time'(halves_of(c) * h), rp, t4 - t2, halves_of(c) * h);
        chk((t1 - t0) == time'(high_of(c) * h), rh, t1 - t0, high_of(c) * h);
        chk((t3 - t2) == time'(high_of(c) * h), rh, t3 - t2, high_of(c) * h);
    endtask

    // Change code mid-cycle and check every pulse against the narrower width.
    task automatic change_code(input logic [2:0] a, input logic [2:0] b);
        time tprev, w, ta;
        int  h, min_hi, min_lo;
        h      = CLK_PERIOD / 2;
        min_hi = (high_of(a) < high_of(b) ? high_of(a) : high_of(b)) * h;
        min_lo = ((halves_of(a) - high_of(a)) < (halves_of(b) - high_of(b)) ?
                  (halves_of(a) - high_of(a)) : (halves_of(b) - high_of(b))) * h;
        @(posedge out_p[0]);
        tprev = $time;
        #7 div_code = b;
        for (int k = 0; k < 8; k++) begin
            @(out_p[0]);
            w = $time - tprev;
            tprev = $time;
            if (out_p[0] == 1'b0) chk(w >= time'(min_hi), "R9 high", w, min_hi);
            else                  chk(w >= time'(min_lo), "R9 low", w, min_lo);
        end
        @(posedge out_p[0]); ta = $time;
        @(posedge out_p[0]);
        chk(($time - ta) == time'(halves_of(b) * h), "R9 period", $time - ta, halves_of(b) * h);
    endtask

    initial begin
        #(CLK_PERIOD * WD_CYCLES);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        time tr, tx;
        // Sweep every code on both sources (R1, R2, R3, R5, R6, R7, R4).
        for (int s = 0; s < 2; s++) begin
            for (int c = 0; c < 8; c++) begin
                run_code(3'(c), s[0]);
            end
        end

        // Reset asserted mid-pulse drops outputs at once (R4).
        run_code(3'd7, 1'b0);
        @(posedge out_p[0]);
        #3 mreset = 1'b1;
        #1;
        chk(out_p == '0, "R4 immediate", out_p, 0);
        chk(out_n == '1, "R4 immediate", out_n, 3);
        repeat (30) @(negedge vco_clk);
        chk(out_p == '0, "R4 held", out_p, 0);

        // Code change inside a cycle waits for its end (R8).
        run_code(3'd7, 1'b0);
        @(posedge out_p[0]);
        tr = $time;
        #5 div_code = 3'd2;
        @(negedge out_p[0]);
        chk(($time - tr) == time'(6 * CLK_PERIOD), "R8 high", $time - tr, 6 * CLK_PERIOD);
        @(posedge out_p[0]);
        chk(($time - tr) == time'(12 * CLK_PERIOD), "R8 period", $time - tr, 12 * CLK_PERIOD);
        tx = $time;
        @(posedge out_p[0]);
        chk(($time - tx) == time'(2 * CLK_PERIOD), "R8 new", $time - tx, 2 * CLK_PERIOD);

        // Chain of ratio changes without runt pulses (R9).
        run_code(3'd7, 1'b0);
        change_code(3'd7, 3'd1);
        change_code(3'd1, 3'd0);
        change_code(3'd0, 3'd5);
        change_code(3'd5, 3'd3);
        change_code(3'd3, 3'd6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule